// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block holds two compare channels. Each channel has its own 16-bit up-counter, a primary and a secondary compare value, and a waveform stage. The waveform stage turns counter matches into one pulse, a toggled pulse train, or a continuous PWM signal. The compare values and mode pins are plain control inputs sampled every clock. No data stream passes through the block, so it has no valid/ready handshake.

Each channel's counter has three run modes, chosen by a 5-bit source select and a trigger-mode bit:

- **Free-running:** the counter counts without stopping.
- **Synchronous:** any pulse on one chosen event line sends the counter back to zero.
- **Trigger:** the counter waits at zero until that line fires, then runs on its own.

When both channels set their join bits, the pair works as one 32-bit compare timer. Channel 0 is the low half and channel 1 is the high half. Channel 0's controls govern the pair.

Top module: `oc_timer_pair`

## Requirements
- R1: With the source select at 0 and the channel enabled, the counter goes up by one on every clock and rolls from 0xFFFF to 0x0000.
- R2: A channel's `evt_pri` flag is high during exactly the cycles in which the channel is enabled and its count equals its primary value. `evt_sec` does the same for the secondary value.
- R3: A nonzero select value k picks event line k, which is bit k-1 of `evt_in`. Pulses on the other lines have no effect on the counter.
- R4: Synchronous mode is a nonzero select with the trigger-mode bit at 0. The counter runs, and a high level on the selected line makes it read 0 after that clock edge.
- R5: Trigger mode is a nonzero select with the trigger-mode bit at 1. The counter stays at 0 until the selected line is high at a clock edge; that edge moves it to 1. From then on it keeps counting with no further events.
- R6: A counter started in trigger mode stops where it is as soon as its select or trigger-mode bit is changed. It waits there for an event on the newly selected line.
- R7: Dropping `ch_en` clears the counter and the output at the next edge, and re-arms single-pulse mode.
- R8: Mode code 2'b11 is PWM. The output goes high on the clock after a primary match and low on the clock after a secondary match. If both values match in the same cycle, the output goes low.
- R9: Mode code 2'b01 is single pulse. The output goes high and low as in PWM for one pulse only, then stays low until a one-cycle `rearm` pulse (or R7) arms it again.
- R10: Mode code 2'b10 inverts the output on the clock after each primary match and ignores the secondary value. Mode code 2'b00 holds the output low.
- R11: With both `cascade` bits set:
  - Channel 1 counts the rollovers of channel 0.
  - A match needs all 32 bits of {count[1],count[0]} to equal the joined compare values.
  - Both outputs carry the waveform built from channel 0's mode, enable, select and trigger settings.
- R12: With only one `cascade` bit set, the two channels run independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on clk |
| ch_en | input | 2 | Per-channel enable |
| src_sel | input | 2x5 | Per-channel event-line select; 0 = free-running |
| trig_mode | input | 2 | Per-channel mode bit: 0 synchronous, 1 trigger |
| cascade | input | 2 | Per-channel join bits; pair joins only when both set |
| out_mode | input | 2x2 | Per-channel waveform mode code |
| rearm | input | 2 | Per-channel single-pulse re-arm strobe |
| cmp_pri | input | 2x16 | Primary compare values |
| cmp_sec | input | 2x16 | Secondary compare values |
| evt_in | input | 31 | Sync/trigger event lines, line k on bit k-1 |
| oc_out | output | 2 | Compare output per channel |
| evt_pri | output | 2 | Primary match flag per channel |
| evt_sec | output | 2 | Secondary match flag per channel |
| count | output | 2x16 | Current counter value per channel |

## Verification
The checks assume that every input is a clean 0 or 1 that changes only between clock edges. They also assume event lines are level-sampled, so a pulse lasting one cycle counts as one event. The `cascade` bits are assumed to stay steady while the joined pair runs; the output-mode checks only hold once the mode has been steady for a cycle. The bench changes every input on the falling clock edge and drives each event and re-arm for a single cycle. Before every new configuration it disables the affected channel for one edge, so each pattern starts from a cleared counter and an armed waveform stage.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [1:0] {
    OUT_OFF    = 2'b00,
    OUT_SINGLE = 2'b01,
    OUT_TOGGLE = 2'b10,
    OUT_PWM    = 2'b11
  } out_mode_e;
endpackage

// File: rtl/oc_ctrl.sv
module oc_ctrl #(
  parameter int SELW = 5,
  parameter int NSRC = 31
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SELW-1:0] sel,
  input  logic            trig,
  input  logic [NSRC-1:0] evt,
  output logic            run,
  output logic            clr
);
  logic            hit, free_run, cfg_chg, started_q;
  logic [SELW:0]   cfg_q;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NSRC; k++)
      if (sel == SELW'(k + 1)) hit = evt[k];
  end

  assign free_run = (sel == '0);
  assign cfg_chg  = ({sel, trig} != cfg_q);

  assign run = en && (free_run ||
                      (!trig && !hit) ||
                      (trig && (hit || (started_q && !cfg_chg))));
  assign clr = !en || (!free_run && !trig && hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cfg_q     <= {sel, trig};
      started_q <= en && trig && !free_run && (hit || (started_q && !cfg_chg));
    end
  end

  // Trigger mode waits with the counter still until an event arrives
  p_trig_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig && !free_run && !hit && !started_q) |-> (!run && !clr));
endmodule

// File: rtl/oc_wave.sv
module oc_wave
  import oc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  out_mode_e mode,
  input  logic      rearm,
  input  logic      hit_pri,
  input  logic      hit_sec,
  output logic      out
);
  logic out_q, armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      out_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      case (mode)
        OUT_TOGGLE: if (hit_pri) out_q <= ~out_q;
        OUT_PWM: begin
          if (hit_sec)      out_q <= 1'b0;
          else if (hit_pri) out_q <= 1'b1;
        end
        OUT_SINGLE: begin
          if (hit_sec && (out_q || (armed_q && hit_pri))) begin
            out_q   <= 1'b0;
            armed_q <= 1'b0;
          end else if (armed_q && hit_pri) begin
            out_q <= 1'b1;
          end
        end
        default: out_q <= 1'b0;
      endcase
      if (rearm) armed_q <= 1'b1;
    end
  end

  assign out = out_q;

  p_disable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !out);
  p_pwm_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == OUT_PWM && hit_sec) |=> !out);
  p_single_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == OUT_SINGLE && !armed_q && !out_q && !rearm) |=> !out);
  p_off_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == OUT_OFF) |=> !out);
endmodule

// File: rtl/oc_timer_pair.sv
module oc_timer_pair
  import oc_pkg::*;
#(
  parameter int CW   = 16,
  parameter int SELW = 5,
  parameter int NSRC = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           ch_en,
  input  logic [1:0][SELW-1:0] src_sel,
  input  logic [1:0]           trig_mode,
  input  logic [1:0]           cascade,
  input  logic [1:0][1:0]      out_mode,
  input  logic [1:0]           rearm,
  input  logic [1:0][CW-1:0]   cmp_pri,
  input  logic [1:0][CW-1:0]   cmp_sec,
  input  logic [NSRC-1:0]      evt_in,
  output logic [1:0]           oc_out,
  output logic [1:0]           evt_pri,
  output logic [1:0]           evt_sec,
  output logic [1:0][CW-1:0]   count
);
  localparam int          NCH     = 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic                    casc, full_pri, full_sec;
  logic [NCH-1:0]          run_c, clr_c, adv, clr, en_eff, hp, hs, rearm_eff;
  logic [NCH-1:0][CW-1:0]  cnt_q;
  out_mode_e               mode_eff [NCH];

  assign casc     = cascade[0] & cascade[1];
  assign full_pri = (cnt_q == cmp_pri);
  assign full_sec = (cnt_q == cmp_sec);

  // Low half (channel 0) always follows its own controls
  assign adv[0] = run_c[0];
  assign clr[0] = clr_c[0];
  // High half either runs alone or counts low-half rollovers
  assign adv[1] = casc ? (run_c[0] && cnt_q[0] == CNT_MAX) : run_c[1];
  assign clr[1] = casc ? clr_c[0] : clr_c[1];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    oc_ctrl #(.SELW(SELW), .NSRC(NSRC)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[g]),
      .sel   (src_sel[g]),
      .trig  (trig_mode[g]),
      .evt   (evt_in),
      .run   (run_c[g]),
      .clr   (clr_c[g])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (clr[g]) cnt_q[g] <= '0;
      else if (adv[g]) cnt_q[g] <= cnt_q[g] + CW'(1);
    end

    assign en_eff[g]    = casc ? ch_en[0] : ch_en[g];
    assign hp[g]        = casc ? full_pri : (cnt_q[g] == cmp_pri[g]);
    assign hs[g]        = casc ? full_sec : (cnt_q[g] == cmp_sec[g]);
    assign rearm_eff[g] = casc ? rearm[0] : rearm[g];
    assign mode_eff[g]  = casc ? out_mode_e'(out_mode[0]) : out_mode_e'(out_mode[g]);

    oc_wave u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_eff[g]),
      .mode    (mode_eff[g]),
      .rearm   (rearm_eff[g]),
      .hit_pri (hp[g]),
      .hit_sec (hs[g]),
      .out     (oc_out[g])
    );
  end

  assign evt_pri = en_eff & hp;
  assign evt_sec = en_eff & hs;
  assign count   = cnt_q;

  p_free_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en[0] && src_sel[0] == '0) |=> (cnt_q[0] == $past(cnt_q[0]) + CW'(1)));
  p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_c[0] |=> (cnt_q[0] == '0));
  p_casc_carry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && run_c[0] && cnt_q[0] == CNT_MAX) |=> (cnt_q[1] == $past(cnt_q[1]) + CW'(1)));
  p_indep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc && !ch_en[1]) |=> (cnt_q[1] == '0));
endmodule

// File: tb/test_oc_timer_pair.sv
module test_oc_timer_pair;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      ch_en = '0;
  logic [1:0][4:0] src_sel = '0;
  logic [1:0]      trig_mode = '0;
  logic [1:0]      cascade = '0;
  logic [1:0][1:0] out_mode = '0;
  logic [1:0]      rearm = '0;
  logic [1:0][15:0] cmp_pri = '0;
  logic [1:0][15:0] cmp_sec = '0;
  logic [30:0]     evt_in = '0;
  logic [1:0]      oc_out, evt_pri, evt_sec;
  logic [1:0][15:0] count;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oc_timer_pair i_oc_timer_pair (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .src_sel(src_sel),
    .trig_mode(trig_mode), .cascade(cascade), .out_mode(out_mode),
    .rearm(rearm), .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .evt_in(evt_in),
    .oc_out(oc_out), .evt_pri(evt_pri), .evt_sec(evt_sec), .count(count)
  );

  typedef struct packed {
    logic [3:0]  rq;
    logic [4:0]  sel;
    logic        trig;
    logic [1:0]  mode;
    logic [15:0] pri;
    logic [15:0] sec;
    logic [7:0]  n;
    logic [15:0] ecnt;
    logic        eout;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  5'd0, 1'b0, 2'b00, 16'd100, 16'd200, 8'd10, 16'd10, 1'b0}, // R1 / R10 off
    '{4'd8,  5'd0, 1'b0, 2'b11, 16'd2,   16'd6,   8'd2,  16'd2,  1'b0}, // R8 before rise
    '{4'd8,  5'd0, 1'b0, 2'b11, 16'd2,   16'd6,   8'd3,  16'd3,  1'b1}, // R8 rise
    '{4'd8,  5'd0, 1'b0, 2'b11, 16'd2,   16'd6,   8'd6,  16'd6,  1'b1}, // R8 still high
    '{4'd8,  5'd0, 1'b0, 2'b11, 16'd2,   16'd6,   8'd7,  16'd7,  1'b0}, // R8 fall
    '{4'd10, 5'd0, 1'b0, 2'b10, 16'd3,   16'd9,   8'd3,  16'd3,  1'b0}, // R10 toggle pending
    '{4'd10, 5'd0, 1'b0, 2'b10, 16'd3,   16'd9,   8'd4,  16'd4,  1'b1}, // R10 toggled
    '{4'd10, 5'd0, 1'b0, 2'b10, 16'd3,   16'd9,   8'd12, 16'd12, 1'b1}, // R10 sec ignored
    '{4'd9,  5'd0, 1'b0, 2'b01, 16'd2,   16'd4,   8'd4,  16'd4,  1'b1}, // R9 pulse high
    '{4'd9,  5'd0, 1'b0, 2'b01, 16'd2,   16'd4,   8'd5,  16'd5,  1'b0}, // R9 pulse done
    '{4'd4,  5'd5, 1'b0, 2'b11, 16'd2,   16'd6,   8'd9,  16'd9,  1'b0}, // R4 sync, no event
    '{4'd5,  5'd5, 1'b1, 2'b11, 16'd1,   16'd6,   8'd9,  16'd0,  1'b0}, // R5 held
    '{4'd8,  5'd0, 1'b0, 2'b11, 16'd4,   16'd4,   8'd6,  16'd6,  1'b0}  // R8 sec wins
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic quiet();
    ch_en = '0; src_sel = '0; trig_mode = '0; cascade = '0;
    out_mode = '0; rearm = '0; cmp_pri = '0; cmp_sec = '0; evt_in = '0;
    step(1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state (R1 counter, R2 flags, R7 output)
    chk("R1 reset count", 32'(count), 32'h0);
    chk("R7 reset output", 32'(oc_out), 32'h0);
    chk("R2 reset flags", {28'h0, evt_pri, evt_sec}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      quiet();
      src_sel[0] = v.sel; trig_mode[0] = v.trig; out_mode[0] = v.mode;
      cmp_pri[0] = v.pri; cmp_sec[0] = v.sec; ch_en[0] = 1'b1;
      step(int'(v.n));
      chk($sformatf("R%0d vector %0d count", v.rq, i), 32'(count[0]), 32'(v.ecnt));
      chk($sformatf("R%0d vector %0d output", v.rq, i), 32'(oc_out[0]), 32'(v.eout));
    end

    // R2: match flags
    quiet();
    out_mode[0] = 2'b11; cmp_pri[0] = 16'd2; cmp_sec[0] = 16'd6; ch_en[0] = 1'b1;
    step(2);
    chk("R2 primary flag", {30'h0, evt_pri[0], evt_sec[0]}, 32'h2);
    step(4);
    chk("R2 secondary flag", {30'h0, evt_pri[0], evt_sec[0]}, 32'h1);

    // R3 / R4: synchronous clear on selected line only
    quiet();
    src_sel[0] = 5'd3; ch_en[0] = 1'b1;
    step(10);
    chk("R4 sync runs", 32'(count[0]), 32'd10);
    evt_in[5] = 1'b1;
    step(1);
    chk("R3 other line ignored", 32'(count[0]), 32'd11);
    evt_in = '0; evt_in[2] = 1'b1;
    step(1);
    chk("R4 sync clear", 32'(count[0]), 32'd0);
    evt_in = '0;
    step(1);
    chk("R4 runs after clear", 32'(count[0]), 32'd1);

    // R5 / R6 / R7: trigger start, restart on reselect, disable
    quiet();
    src_sel[0] = 5'd2; trig_mode[0] = 1'b1; ch_en[0] = 1'b1;
    step(5);
    chk("R5 held before trigger", 32'(count[0]), 32'd0);
    evt_in[1] = 1'b1;
    step(1);
    chk("R5 trigger starts", 32'(count[0]), 32'd1);
    evt_in = '0;
    step(4);
    chk("R5 keeps running", 32'(count[0]), 32'd5);
    src_sel[0] = 5'd4;
    step(3);
    chk("R6 stops on reselect", 32'(count[0]), 32'd5);
    evt_in[3] = 1'b1;
    step(1);
    evt_in = '0;
    step(2);
    chk("R6 restarts on new line", 32'(count[0]), 32'd8);
    ch_en[0] = 1'b0;
    step(1);
    chk("R7 disable clears count", 32'(count[0]), 32'd0);

    // R9 / R7: single pulse, no repeat, re-arm
    quiet();
    src_sel[0] = 5'd1; out_mode[0] = 2'b01;
    cmp_pri[0] = 16'd2; cmp_sec[0] = 16'd4; ch_en[0] = 1'b1;
    step(8);
    chk("R9 low after pulse", 32'(oc_out[0]), 32'd0);
    evt_in[0] = 1'b1;
    step(1);
    evt_in = '0;
    step(3);
    chk("R9 no second pulse", {oc_out[0], count[0]}, {16'h0, 16'd3});
    evt_in[0] = 1'b1; rearm[0] = 1'b1;
    step(1);
    evt_in = '0; rearm[0] = 1'b0;
    step(3);
    chk("R9 pulse after rearm", 32'(oc_out[0]), 32'd1);
    step(2);
    chk("R9 rearmed pulse ends", {oc_out[0], count[0]}, {16'h0, 16'd5});
    ch_en[0] = 1'b0;
    step(1);
    chk("R7 disable clears output", 32'(oc_out[0]), 32'd0);
    ch_en[0] = 1'b1;
    step(3);
    chk("R7 disable re-arms", 32'(oc_out[0]), 32'd1);

    // R12: one join bit only keeps channels apart
    quiet();
    cascade = 2'b01; ch_en = 2'b11;
    step(10);
    chk("R12 high channel independent", 32'(count[1]), 32'd10);
    chk("R12 low channel independent", 32'(count[0]), 32'd10);

    // R11: joined 32-bit operation
    quiet();
    cascade = 2'b11; step(1);
    src_sel[1] = 5'd3; trig_mode[1] = 1'b1;          // ignored when joined
    out_mode[0] = 2'b11;
    cmp_pri[0] = 16'd3; cmp_pri[1] = 16'd1;
    cmp_sec[0] = 16'd5; cmp_sec[1] = 16'd1;
    ch_en[0] = 1'b1;
    step(4);
    chk("R11 low half alone no match", 32'(oc_out), 32'd0);
    step(65532);
    chk("R11 carry into high half", {count[1], count[0]}, {16'd1, 16'd0});
    chk("R1 low half wrapped", 32'(count[0]), 32'd0);
    step(4);
    chk("R11 32-bit match drives both", 32'(oc_out), 32'd3);
    step(3);
    chk("R11 32-bit secondary clears", 32'(oc_out), 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule